// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Chain

This block models a row of interrupting devices that share one request line to the processor. Each device holds a pending flag. The OR of all pending flags drives the shared request output. When the processor raises acknowledge, the signal enters the first node and travels down the chain. A node with nothing pending passes it on. The first pending node on the path stops it and drives its own vector. Node 0 therefore has the highest priority, and priority falls with the node index.

The acknowledge level works as the handshake for the vector output. The vector and its valid flag are combinational from acknowledge and stay steady for as long as acknowledge is held. A processor that needs more time simply keeps acknowledge high, which is the only form of back-pressure. When acknowledge drops, the node that was served clears its flag, and every other node keeps its own. If acknowledge passes the last node without meeting a requester, a no-vector flag tells the processor the acknowledge was spurious.

Top module: `intack_chain`

## Requirements
- R1: After reset, no node is pending, and irq_out, vec_valid, no_vec and vec_out are all 0.
- R2: A 1 sampled on dev_req[i] at a clock edge, while node i has no acknowledge arriving, sets node i pending, and irq_out is 1 after that edge.
- R3: While ack_in is 1 and at least one node is pending, vec_valid is 1 in the same cycle and vec_out carries the vector of the pending node with the lowest index.
- R4: The vector of node i is (VEC_BASE + i*VEC_STEP) modulo 2^VEC_W.
- R5: At most one node is granted in any cycle.
- R6: At the first clock edge with ack_in at 0 after a grant, the served node clears its pending flag. All other pending nodes stay pending, and irq_out stays 1 while any of them remain.
- R7: A request sampled at a node while acknowledge reaches that node (at a node upstream of the granted one, or at the granted node itself) is held back. It becomes pending at the first edge after ack_in drops, so the vector does not change during an acknowledge.
- R8: While ack_in is 1 and no node is pending, no_vec is 1, vec_valid is 0 and vec_out is 0.
- R9: While ack_in is 0, vec_out is 0 and both vec_valid and no_vec are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | N_NODES | Per-node request inputs; bit i belongs to node i |
| ack_in | input | 1 | Acknowledge from the processor, entering node 0 |
| irq_out | output | 1 | Shared request line, the OR of all pending flags |
| vec_out | output | VEC_W | Vector of the granted node, 0 when none |
| vec_valid | output | 1 | A node is granted and vec_out is meaningful |
| no_vec | output | 1 | Acknowledge passed the whole chain without a requester |

## Verification
The bench builds the chain with five nodes, 8-bit vectors, base 0x20 and step 0x04. Every node therefore has a distinct and recognisable vector, and the mid-chain cases can be reached: a grant with requesters both above and below it, and a request held back at a node upstream of the grant. Five nodes is also enough to drain a full set of pending requests in priority order, with the last node's vector checked at the end of the chain.

// File: rtl/intack_pkg.sv
package intack_pkg;

  // Vector for node idx, before truncation to the vector width.
  function automatic int unsigned node_vector(input int unsigned base,
                                              input int unsigned step,
                                              input int unsigned idx);
    return base + idx * step;
  endfunction

endpackage

// File: rtl/intack_node.sv
module intack_node #(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] NODE_VEC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_req,
  input  logic             pri_in,
  output logic             pri_out,
  output logic             granted,
  output logic             pending,
  output logic [VEC_W-1:0] vec
);

  logic pend_q;
  logic defer_q;
  logic grant_q;
  logic release_w;

  // Priority path: block acknowledge when this node wants service.
  always_comb begin
    granted   = pend_q & pri_in;
    pri_out   = pri_in & ~pend_q;
    vec       = granted ? NODE_VEC : '0;
    release_w = grant_q & ~pri_in;
  end

  assign pending = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      defer_q <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      grant_q <= granted;
      if (pri_in) begin
        // Acknowledge is present here: park new requests.
        defer_q <= defer_q | dev_req;
      end else begin
        pend_q  <= (pend_q & ~release_w) | defer_q | dev_req;
        defer_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/intack_merge.sv
module intack_merge #(
  parameter int N_NODES = 4,
  parameter int VEC_W   = 8
) (
  input  logic [N_NODES-1:0]       pend,
  input  logic [N_NODES-1:0]       grant,
  input  logic [N_NODES*VEC_W-1:0] vecs,
  output logic                     irq,
  output logic                     any_grant,
  output logic [VEC_W-1:0]         vec
);

  logic [VEC_W-1:0] acc [N_NODES+1];

  assign acc[0] = '0;

  generate
    for (genvar i = 0; i < N_NODES; i++) begin : g_or
      assign acc[i+1] = acc[i] | vecs[i*VEC_W +: VEC_W];
    end
  endgenerate

  assign vec       = acc[N_NODES];
  assign irq       = |pend;
  assign any_grant = |grant;

endmodule

// File: rtl/intack_chain.sv
module intack_chain #(
  parameter int N_NODES  = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32'h40,
  parameter int VEC_STEP = 32'h08
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_NODES-1:0] dev_req,
  input  logic               ack_in,
  output logic               irq_out,
  output logic [VEC_W-1:0]   vec_out,
  output logic               vec_valid,
  output logic               no_vec
);
  import intack_pkg::*;

  localparam int VBUS_W = N_NODES * VEC_W;

  logic [N_NODES:0]      pri_link;
  logic [N_NODES-1:0]    grant_w;
  logic [N_NODES-1:0]    pend_w;
  logic [VBUS_W-1:0]     vec_bus;

  assign pri_link[0] = ack_in;

  generate
    for (genvar i = 0; i < N_NODES; i++) begin : g_node
      localparam int unsigned RAW = node_vector(VEC_BASE, VEC_STEP, i);
      localparam logic [VEC_W-1:0] NV = RAW[VEC_W-1:0];
      intack_node #(
        .VEC_W   (VEC_W),
        .NODE_VEC(NV)
      ) u_node (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_req (dev_req[i]),
        .pri_in  (pri_link[i]),
        .pri_out (pri_link[i+1]),
        .granted (grant_w[i]),
        .pending (pend_w[i]),
        .vec     (vec_bus[i*VEC_W +: VEC_W])
      );
    end
  endgenerate

  intack_merge #(
    .N_NODES(N_NODES),
    .VEC_W  (VEC_W)
  ) u_merge (
    .pend     (pend_w),
    .grant    (grant_w),
    .vecs     (vec_bus),
    .irq      (irq_out),
    .any_grant(vec_valid),
    .vec      (vec_out)
  );

  // Acknowledge that fell off the end of the chain.
  assign no_vec = pri_link[N_NODES];

endmodule

// File: rtl/intack_chain_chk.sv
module intack_chain_chk #(
  parameter int N_NODES = 4,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ack_in,
  input logic               irq_out,
  input logic               vec_valid,
  input logic               no_vec,
  input logic [VEC_W-1:0]   vec_out,
  input logic [N_NODES-1:0] grant_w
);

  // R5
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_w));

  // R3
  pending_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && irq_out) |-> (vec_valid && !no_vec));

  // R8
  spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && !irq_out) |-> (no_vec && !vec_valid && vec_out == '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_in |-> (!vec_valid && !no_vec && vec_out == '0));

  // R7
  held_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && vec_valid) |=> (ack_in -> (vec_valid && $stable(vec_out))));

endmodule

bind intack_chain intack_chain_chk #(
  .N_NODES(N_NODES),
  .VEC_W  (VEC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack_in   (ack_in),
  .irq_out  (irq_out),
  .vec_valid(vec_valid),
  .no_vec   (no_vec),
  .vec_out  (vec_out),
  .grant_w  (grant_w)
);

// File: tb/intack_chain_bench.sv
module intack_chain_bench;
  localparam int N  = 5;
  localparam int W  = 8;
  localparam int VB = 32'h20;
  localparam int VS = 32'h04;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] dev_req = '0;
  logic         ack_in = 1'b0;
  logic         irq_out;
  logic [W-1:0] vec_out;
  logic         vec_valid;
  logic         no_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  intack_chain #(
    .N_NODES(N), .VEC_W(W), .VEC_BASE(VB), .VEC_STEP(VS)
  ) u_intack_chain (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .ack_in(ack_in),
    .irq_out(irq_out), .vec_out(vec_out), .vec_valid(vec_valid), .no_vec(no_vec)
  );

  function automatic logic [W-1:0] exp_vec(input int idx);
    int unsigned r;
    r = VB + idx * VS;
    return r[W-1:0];
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Inputs change just after a falling edge; checks run 1 ns later.
  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic raise(input int idx);
    nxt(); dev_req[idx] = 1'b1;
    nxt(); dev_req[idx] = 1'b0;
    #1;
  endtask

  task automatic ack_on();
    nxt(); ack_in = 1'b1; #1;
  endtask

  task automatic ack_off();
    nxt(); ack_in = 1'b0;
    nxt(); #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 irq", irq_out, 0);
    chk("R1 valid", vec_valid, 0);
    chk("R1 novec", no_vec, 0);
    chk("R1 vec", vec_out, 0);
  endtask

  task automatic t_single();
    for (int i = 0; i < N; i++) begin
      raise(i);
      chk("R2 irq", irq_out, 1);
      ack_on();
      chk("R3 valid", vec_valid, 1);
      chk("R4 vec", vec_out, exp_vec(i));
      ack_off();
      chk("R6 cleared", irq_out, 0);
      chk("R9 vec idle", vec_out, 0);
    end
  endtask

  task automatic t_priority();
    nxt(); dev_req = 5'b10110;
    nxt(); dev_req = '0; #1;
    chk("R2 irq multi", irq_out, 1);
    for (int k = 0; k < 3; k++) begin
      int idx;
      idx = (k == 0) ? 1 : (k == 1) ? 2 : 4;
      ack_on();
      chk("R3 lowest first", vec_out, exp_vec(idx));
      chk("R8 novec low", no_vec, 0);
      ack_off();
      chk("R6 remaining irq", irq_out, (k < 2) ? 1 : 0);
    end
  endtask

  task automatic t_spurious();
    ack_on();
    chk("R8 novec", no_vec, 1);
    chk("R8 valid", vec_valid, 0);
    chk("R8 vec", vec_out, 0);
    ack_off();
    chk("R9 novec idle", no_vec, 0);
  endtask

  task automatic t_defer();
    raise(2);
    ack_on();
    chk("R7 grant", vec_out, exp_vec(2));
    dev_req[0] = 1'b1;
    nxt(); dev_req[0] = 1'b0; #1;
    chk("R7 still node2", vec_out, exp_vec(2));
    chk("R7 valid", vec_valid, 1);
    ack_off();
    chk("R7 irq after release", irq_out, 1);
    ack_on();
    chk("R7 held request served", vec_out, exp_vec(0));
    ack_off();
    chk("R6 empty", irq_out, 0);
  endtask

  task automatic t_rearm();
    raise(3);
    ack_on();
    dev_req[3] = 1'b1;
    nxt(); dev_req[3] = 1'b0; #1;
    chk("R7 rearm same vec", vec_out, exp_vec(3));
    ack_off();
    chk("R7 rearm irq", irq_out, 1);
    ack_on();
    chk("R7 rearm served", vec_out, exp_vec(3));
    ack_off();
    chk("R6 rearm cleared", irq_out, 0);
  endtask

  initial begin
    repeat (3) nxt();
    t_reset();
    rst_n = 1'b1;
    t_single();
    t_priority();
    t_spurious();
    t_defer();
    t_rearm();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule